// File: doc/BRIEF.md
# Receive Byte-Lane to XGMII Word Decoder

This block sits in the receive path of a 2.5 Gb/s backplane PCS. Its input is a group of four byte lanes that are already aligned and decoded. Each lane carries an enable bit, an error bit and a data byte, coded as on a gigabit media-independent interface. The block turns each group into one 32-bit XGMII receive word with four control flags.

The mapping depends on the kind of the previous word: idle, data or sequence. A data group that follows an idle word opens a packet with a start character. The first idle or carrier-extend lane after data closes the packet with a terminate character. A sequence ordered set arrives as two groups. The block accepts it only after it has looked at the second group and checked the four marker bits. It then emits the rebuilt XGMII sequence word once for each of the two groups.

While the link is down the output is a steady local-fault ordered set. Any unlisted pattern becomes error characters. The one-group look-ahead adds a fixed latency to every word, so the order of output words always matches the order of input groups.

Top module: `xgmii_rx_word_decoder`

## Requirements
- R1: When the previous output word is not a data word and all four lanes carry data (enable=1, error=0) or error (enable=1, error=1), the output is a start character (0xFB, control) in lane 0. Lanes 1 to 3 follow as data, and the word state becomes data.
- R2: An all-data group while the word state is data passes through unchanged with control flags 0. A lane with enable=1 and error=1 becomes the error character 0xFE with its control flag set.
- R3: While in data, a group of data lanes followed by one lane that is idle (enable=0, error=0) or carrier extend (enable=0, error=1, byte 0x0F), and then only idle lanes, is closed as follows: the first such lane becomes terminate (0xFD, control) and the later lanes become idle (0x07, control). An all-idle group after data gives terminate in lane 0. At most one terminate appears in a word.
- R4: An all-idle group while not in data gives four idle characters (0x07, control 4'b1111).
- R5: Four low-power-idle lanes (enable=0, error=1, byte 0x01), or idle, idle, LPI, LPI, give four LPI characters (0x06, control 4'b1111). LPI, LPI, idle, idle gives an idle word.
- R6: The group (Seq, S0, Seq, S1) is accepted when the next group is (Seq, S2, Seq, S3) and bit 7 of S0..S3 reads 0,1,1,0. A Seq lane is enable=0, error=1, byte 0x9C; an S lane is a data lane. Both groups then give the word {Z, Y, X, 0x9C} with control 4'b0001, where X={S1[1:0],S0[5:0]}, Y={S2[3:0],S1[5:2]} and Z={S3[5:0],S2[5:4]}.
- R7: A (Seq, S, Seq, S) group that fails the marker check, or that is not followed by a valid second half, gives an idle word.
- R8: Any other pattern gives four error characters (0xFE, control 4'b1111), and the word state is left unchanged. This covers false carrier (byte 0x0E), carrier-extend error (byte 0x1F) and a carrier extend in the wrong lane.
- R9: For a group presented while link_up is 0, the output is local fault (data 0x0100009C, control 4'b0001), and the word state returns to idle.
- R10: Each group appears at the output two rising clock edges after it is presented. During reset the output is local fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one lane group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Receive link status, travels with the group |
| rx_en | input | 4 | Per-lane enable bit, lane i at bit i |
| rx_er | input | 4 | Per-lane error bit, lane i at bit i |
| rx_d | input | 32 | Per-lane byte, lane i at bits 8i+7:8i |
| xg_d | output | 32 | XGMII receive data, lane i at bits 8i+7:8i |
| xg_c | output | 4 | XGMII receive control flags, lane i at bit i |

## Verification
A wrong word state shows at the ports on the very next packet boundary, one word after it occurs. If the state sticks at data, an idle group turns into a stray terminate. If it sticks at idle, a body group gains a spurious start. A broken look-ahead or marker check shows within two words: a sequence word either goes missing or turns up without its twin. A link-down group that fails to clear the state shows when the link returns, because the first data group then lacks its start character.

// File: rtl/xrwd_pkg.sv
package xrwd_pkg;
  localparam int LANES      = 4;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = LANES * BYTE_W;
  localparam int SEQ_W      = 3 * BYTE_W;
  localparam int LANE_IDX_W = $clog2(LANES);

  // lane byte codes when enable=0, error=1
  localparam logic [BYTE_W-1:0] GC_LPI  = 8'h01;
  localparam logic [BYTE_W-1:0] GC_CEXT = 8'h0F;
  localparam logic [BYTE_W-1:0] GC_SEQ  = 8'h9C;

  // XGMII control characters
  localparam logic [BYTE_W-1:0] XC_IDLE  = 8'h07;
  localparam logic [BYTE_W-1:0] XC_LPI   = 8'h06;
  localparam logic [BYTE_W-1:0] XC_START = 8'hFB;
  localparam logic [BYTE_W-1:0] XC_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] XC_ERR   = 8'hFE;
  localparam logic [BYTE_W-1:0] XC_SEQ   = 8'h9C;

  localparam logic [WORD_W-1:0] LF_DATA = 32'h0100_009C;
  localparam logic [LANES-1:0]  LF_CTRL = 4'b0001;

  typedef struct packed {
    logic              en;
    logic              er;
    logic [BYTE_W-1:0] d;
  } lane_t;

  typedef enum logic [2:0] {
    LC_DATA, LC_ERR, LC_IDLE, LC_LPI, LC_CEXT, LC_SEQ, LC_BAD
  } lane_cls_e;

  typedef enum logic [1:0] {PS_IDLE, PS_DATA, PS_SEQ} prev_e;

  typedef lane_t     [LANES-1:0] lane_grp_t;
  typedef lane_cls_e [LANES-1:0] cls_grp_t;

  function automatic lane_cls_e classify(lane_t l);
    if (l.en) return l.er ? LC_ERR : LC_DATA;
    if (!l.er) return LC_IDLE;
    case (l.d)
      GC_LPI:  return LC_LPI;
      GC_CEXT: return LC_CEXT;
      GC_SEQ:  return LC_SEQ;
      default: return LC_BAD;
    endcase
  endfunction

  // {ctrl, byte} for a lane that holds data or error
  function automatic logic [BYTE_W:0] body_lane(lane_cls_e c, logic [BYTE_W-1:0] b);
    return (c == LC_DATA) ? {1'b0, b} : {1'b1, XC_ERR};
  endfunction

  // s2 and s3 carry bit 7 followed by bits 5:0; returns {Z, Y, X}
  function automatic logic [SEQ_W-1:0] seq_unpack(logic [7:0] s0, logic [7:0] s1,
                                                   logic [6:0] s2, logic [6:0] s3);
    logic [7:0] x, y, z;
    x = {s1[1:0], s0[5:0]};
    y = {s2[3:0], s1[5:2]};
    z = {s3[5:0], s2[5:4]};
    return {z, y, x};
  endfunction

  function automatic logic is_seq_shape(cls_grp_t c);
    return (c[0] == LC_SEQ) && (c[1] == LC_DATA) && (c[2] == LC_SEQ) && (c[3] == LC_DATA);
  endfunction
endpackage

// File: rtl/xrwd_lane_class.sv
module xrwd_lane_class
  import xrwd_pkg::*;
(
  input  lane_grp_t grp,
  output cls_grp_t  cls
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cls[g] = classify(grp[g]);
  end
endmodule

// File: rtl/xrwd_group_map.sv
module xrwd_group_map
  import xrwd_pkg::*;
(
  input  logic [WORD_W-1:0] cur_bytes,
  input  cls_grp_t          cur_cls,
  input  cls_grp_t          nxt_cls,
  input  logic [6:0]        nxt_s2,
  input  logic [6:0]        nxt_s3,
  input  prev_e             st,
  input  logic [SEQ_W-1:0]  seq_hold,
  output logic [WORD_W-1:0] map_d,
  output logic [LANES-1:0]  map_c,
  output prev_e             nst,
  output logic              seq_first,
  output logic [SEQ_W-1:0]  seq_new
);
  logic [LANES-1:0] is_body, is_idle, is_close, is_lpi;
  logic all_body, all_idle, lpi_full, lpi_late, lpi_early;
  logic cur_shape, marks_ok, first_ok;
  logic term_hit;
  int   term_at;

  for (genvar g = 0; g < LANES; g++) begin : g_flags
    assign is_body[g]  = (cur_cls[g] == LC_DATA) || (cur_cls[g] == LC_ERR);
    assign is_idle[g]  = (cur_cls[g] == LC_IDLE);
    assign is_close[g] = (cur_cls[g] == LC_IDLE) || (cur_cls[g] == LC_CEXT);
    assign is_lpi[g]   = (cur_cls[g] == LC_LPI);
  end

  assign all_body  = &is_body;
  assign all_idle  = &is_idle;
  assign lpi_full  = &is_lpi;
  assign lpi_late  = is_idle[0] & is_idle[1] & is_lpi[2] & is_lpi[3];
  assign lpi_early = is_lpi[0] & is_lpi[1] & is_idle[2] & is_idle[3];

  assign cur_shape = is_seq_shape(cur_cls);
  assign marks_ok  = !cur_bytes[BYTE_W+7] && cur_bytes[3*BYTE_W+7] && nxt_s2[6] && !nxt_s3[6];
  assign first_ok  = cur_shape && is_seq_shape(nxt_cls) && marks_ok;
  assign seq_new   = seq_unpack(cur_bytes[BYTE_W +: BYTE_W], cur_bytes[3*BYTE_W +: BYTE_W],
                                nxt_s2, nxt_s3);

  // first lane that can close a packet
  always_comb begin
    term_hit = 1'b0;
    term_at  = 0;
    for (int n = 0; n < LANES; n++) begin
      logic ok;
      ok = is_close[n];
      for (int k = 0; k < LANES; k++) begin
        if (k < n) ok = ok & is_body[k];
        if (k > n) ok = ok & is_idle[k];
      end
      if (ok && !term_hit) begin
        term_hit = 1'b1;
        term_at  = n;
      end
    end
  end

  always_comb begin
    map_d     = {LANES{XC_ERR}};
    map_c     = '1;
    nst       = st;
    seq_first = 1'b0;
    if (st == PS_SEQ && cur_shape) begin
      map_d = {seq_hold, XC_SEQ};
      map_c = 4'b0001;
      nst   = PS_IDLE;
    end else if (all_body) begin
      for (int g = 0; g < LANES; g++)
        {map_c[g], map_d[g*BYTE_W +: BYTE_W]} = body_lane(cur_cls[g], cur_bytes[g*BYTE_W +: BYTE_W]);
      if (st == PS_IDLE) begin
        map_d[BYTE_W-1:0] = XC_START;
        map_c[0]          = 1'b1;
      end
      nst = PS_DATA;
    end else if (st == PS_DATA && term_hit) begin
      for (int g = 0; g < LANES; g++) begin
        if (g < term_at)
          {map_c[g], map_d[g*BYTE_W +: BYTE_W]} = body_lane(cur_cls[g], cur_bytes[g*BYTE_W +: BYTE_W]);
        else if (g == term_at)
          {map_c[g], map_d[g*BYTE_W +: BYTE_W]} = {1'b1, XC_TERM};
        else
          {map_c[g], map_d[g*BYTE_W +: BYTE_W]} = {1'b1, XC_IDLE};
      end
      nst = PS_IDLE;
    end else if (all_idle || lpi_early) begin
      map_d = {LANES{XC_IDLE}};
      nst   = PS_IDLE;
    end else if (lpi_full || lpi_late) begin
      map_d = {LANES{XC_LPI}};
      nst   = PS_IDLE;
    end else if (first_ok) begin
      map_d     = {seq_new, XC_SEQ};
      map_c     = 4'b0001;
      nst       = PS_SEQ;
      seq_first = 1'b1;
    end else if (cur_shape) begin
      map_d = {LANES{XC_IDLE}};
      nst   = PS_IDLE;
    end
  end
endmodule

// File: rtl/xrwd_word_reg.sv
module xrwd_word_reg
  import xrwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_link,
  input  logic [WORD_W-1:0] map_d,
  input  logic [LANES-1:0]  map_c,
  input  prev_e             nst,
  input  logic              seq_first,
  input  logic [SEQ_W-1:0]  seq_new,
  output logic [WORD_W-1:0] xg_d,
  output logic [LANES-1:0]  xg_c,
  output prev_e             st_q,
  output logic [SEQ_W-1:0]  seq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xg_d  <= LF_DATA;
      xg_c  <= LF_CTRL;
      st_q  <= PS_IDLE;
      seq_q <= '0;
    end else if (!cur_link) begin
      xg_d  <= LF_DATA;
      xg_c  <= LF_CTRL;
      st_q  <= PS_IDLE;
    end else begin
      xg_d <= map_d;
      xg_c <= map_c;
      st_q <= nst;
      if (seq_first) seq_q <= seq_new;
    end
  end
endmodule

// File: rtl/xgmii_rx_word_decoder.sv
module xgmii_rx_word_decoder
  import xrwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [LANES-1:0]  rx_en,
  input  logic [LANES-1:0]  rx_er,
  input  logic [WORD_W-1:0] rx_d,
  output logic [WORD_W-1:0] xg_d,
  output logic [LANES-1:0]  xg_c
);
  lane_grp_t         nxt_grp, cur_grp;
  cls_grp_t          nxt_cls, cur_cls;
  logic              cur_link;
  logic [WORD_W-1:0] cur_bytes;
  logic [6:0]        nxt_s2, nxt_s3;
  logic [WORD_W-1:0] map_d;
  logic [LANES-1:0]  map_c;
  prev_e             nst, st_q;
  logic              seq_first;
  logic [SEQ_W-1:0]  seq_new, seq_q;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign nxt_grp[g]                     = '{en: rx_en[g], er: rx_er[g], d: rx_d[g*BYTE_W +: BYTE_W]};
    assign cur_bytes[g*BYTE_W +: BYTE_W] = cur_grp[g].d;
  end

  assign nxt_s2 = {nxt_grp[1].d[7], nxt_grp[1].d[5:0]};
  assign nxt_s3 = {nxt_grp[3].d[7], nxt_grp[3].d[5:0]};

  // look-ahead stage: the group at the ports is the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_grp  <= '0;
      cur_link <= 1'b0;
    end else begin
      cur_grp  <= nxt_grp;
      cur_link <= link_up;
    end
  end

  xrwd_lane_class u_cls_nxt (.grp(nxt_grp), .cls(nxt_cls));
  xrwd_lane_class u_cls_cur (.grp(cur_grp), .cls(cur_cls));

  xrwd_group_map u_map (
    .cur_bytes(cur_bytes), .cur_cls(cur_cls), .nxt_cls(nxt_cls),
    .nxt_s2(nxt_s2), .nxt_s3(nxt_s3), .st(st_q), .seq_hold(seq_q),
    .map_d(map_d), .map_c(map_c), .nst(nst), .seq_first(seq_first), .seq_new(seq_new)
  );

  xrwd_word_reg u_reg (
    .clk(clk), .rst_n(rst_n), .cur_link(cur_link),
    .map_d(map_d), .map_c(map_c), .nst(nst), .seq_first(seq_first), .seq_new(seq_new),
    .xg_d(xg_d), .xg_c(xg_c), .st_q(st_q), .seq_q(seq_q)
  );
endmodule

// File: rtl/xrwd_checker.sv
module xrwd_checker
  import xrwd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cur_link,
  input prev_e             st_q,
  input logic [WORD_W-1:0] xg_d,
  input logic [LANES-1:0]  xg_c
);
  logic [LANES-1:0] term_lane;
  logic out_start, out_seq;

  for (genvar g = 0; g < LANES; g++) begin : g_term
    assign term_lane[g] = xg_c[g] && (xg_d[g*BYTE_W +: BYTE_W] == XC_TERM);
  end
  assign out_start = xg_c[0] && (xg_d[BYTE_W-1:0] == XC_START);
  assign out_seq   = (xg_c == 4'b0001) && (xg_d[BYTE_W-1:0] == XC_SEQ);

  assert_fault_on_link_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_link |=> (xg_c == LF_CTRL && xg_d == LF_DATA));

  assert_single_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term_lane));

  assert_no_back_to_back_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |=> !out_start);

  assert_start_enters_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> st_q == PS_DATA);

  assert_seq_state_has_seq_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SEQ) |-> out_seq);

  assert_seq_word_repeats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SEQ && cur_link) |=> (xg_d == $past(xg_d) && xg_c == $past(xg_c)));
endmodule

bind xgmii_rx_word_decoder xrwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cur_link(cur_link), .st_q(st_q), .xg_d(xg_d), .xg_c(xg_c)
);

// File: tb/xgmii_rx_word_decoder_tb.sv
module xgmii_rx_word_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic [3:0]  rx_en = '0;
  logic [3:0]  rx_er = '0;
  logic [31:0] rx_d = '0;
  logic [31:0] xg_d;
  logic [3:0]  xg_c;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          due_q[$];
  logic [31:0] ed_q[$];
  logic [3:0]  ec_q[$];
  string       tag_q[$];

  localparam logic [9:0] LI   = 10'h000;
  localparam logic [9:0] LERR = {2'b11, 8'h00};
  localparam logic [9:0] LLPI = {2'b01, 8'h01};
  localparam logic [9:0] LSEQ = {2'b01, 8'h9C};
  localparam logic [9:0] LCE  = {2'b01, 8'h0F};
  localparam logic [9:0] LFC  = {2'b01, 8'h0E};
  localparam logic [31:0] W_IDLE = 32'h0707_0707;
  localparam logic [31:0] W_LPI  = 32'h0606_0606;
  localparam logic [31:0] W_ERR  = 32'hFEFE_FEFE;
  localparam logic [31:0] W_LF   = 32'h0100_009C;

  xgmii_rx_word_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .rx_en(rx_en), .rx_er(rx_er),
    .rx_d(rx_d), .xg_d(xg_d), .xg_c(xg_c)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [9:0] ld(input logic [7:0] b);
    return {2'b10, b};
  endfunction

  task automatic check(input string tag, input logic [31:0] ad, input logic [3:0] ac,
                       input logic [31:0] ed, input logic [3:0] ec);
    n_chk++;
    if (ad !== ed || ac !== ec) begin
      n_bad++;
      $display("FAIL %s actual d=%h c=%b expected d=%h c=%b", tag, ad, ac, ed, ec);
    end
  endtask

  // driver: presents one group and queues the word expected two edges later
  task automatic put(input logic [9:0] l0, input logic [9:0] l1, input logic [9:0] l2,
                     input logic [9:0] l3, input logic lk, input bit chk,
                     input logic [31:0] ed, input logic [3:0] ec, input string tag);
    logic [9:0] lv [4];
    @(negedge clk);
    lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3;
    for (int g = 0; g < 4; g++) begin
      rx_en[g]        = lv[g][9];
      rx_er[g]        = lv[g][8];
      rx_d[g*8 +: 8]  = lv[g][7:0];
    end
    link_up = lk;
    if (chk) begin
      due_q.push_back(cyc + 2);
      ed_q.push_back(ed);
      ec_q.push_back(ec);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: compares as words emerge
  always @(negedge clk) begin
    #1;
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      check(tag_q[0], xg_d, xg_c, ed_q[0], ec_q[0]);
      void'(due_q.pop_front());
      void'(ed_q.pop_front());
      void'(ec_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R10 reset output", xg_d, xg_c, W_LF, 4'b0001);
    @(negedge clk);
    #1 check("R10 reset held", xg_d, xg_c, W_LF, 4'b0001);
    rst_n = 1'b1;

    put(LI, LI, LI, LI, 1'b0, 1, W_LF, 4'b0001, "R9 link down");
    put(LI, LI, LI, LI, 1'b1, 1, W_IDLE, 4'b1111, "R4 idle group");
    put(ld(8'h55), ld(8'h11), ld(8'h22), ld(8'h33), 1'b1, 1, 32'h3322_11FB, 4'b0001, "R1 start");
    put(ld(8'h44), ld(8'h55), ld(8'h66), ld(8'h77), 1'b1, 1, 32'h7766_5544, 4'b0000, "R2 body");
    put(ld(8'h88), LERR, ld(8'h99), ld(8'hAA), 1'b1, 1, 32'hAA99_FE88, 4'b0010, "R2 error lane");
    put(ld(8'hBB), ld(8'hCC), LI, LI, 1'b1, 1, 32'h07FD_CCBB, 4'b1100, "R3 term lane2");
    put(LI, LI, LI, LI, 1'b1, 1, W_IDLE, 4'b1111, "R4 idle after term");
    put(ld(8'h55), ld(8'h01), ld(8'h02), ld(8'h03), 1'b1, 1, 32'h0302_01FB, 4'b0001, "R1 start again");
    put(LI, LI, LI, LI, 1'b1, 1, 32'h0707_07FD, 4'b1111, "R3 term lane0");
    put(ld(8'h55), ld(8'h04), ld(8'h05), ld(8'h06), 1'b1, 1, 32'h0605_04FB, 4'b0001, "R1 start");
    put(ld(8'h07), LCE, LI, LI, 1'b1, 1, 32'h0707_FD07, 4'b1110, "R3 term on carrier extend");
    put(ld(8'h55), ld(8'h0A), ld(8'h0B), ld(8'h0C), 1'b1, 1, 32'h0C0B_0AFB, 4'b0001, "R1 start");
    put(ld(8'h10), ld(8'h20), ld(8'h30), LI, 1'b1, 1, 32'hFD30_2010, 4'b1000, "R3 term lane3");
    put(LLPI, LLPI, LLPI, LLPI, 1'b1, 1, W_LPI, 4'b1111, "R5 full lpi");
    put(LI, LI, LLPI, LLPI, 1'b1, 1, W_LPI, 4'b1111, "R5 late lpi");
    put(LLPI, LLPI, LI, LI, 1'b1, 1, W_IDLE, 4'b1111, "R5 early lpi is idle");
    // X=A5 Y=3C Z=E7 packed into S0..S3 with markers 0,1,1,0
    put(LSEQ, ld(8'h25), LSEQ, ld(8'hB2), 1'b1, 1, 32'hE73C_A59C, 4'b0001, "R6 seq first");
    put(LSEQ, ld(8'hB3), LSEQ, ld(8'h39), 1'b1, 1, 32'hE73C_A59C, 4'b0001, "R6 seq second");
    put(LSEQ, ld(8'h25), LSEQ, ld(8'hB2), 1'b1, 1, W_IDLE, 4'b1111, "R7 marker 0100 first");
    put(LSEQ, ld(8'h33), LSEQ, ld(8'h39), 1'b1, 1, W_IDLE, 4'b1111, "R7 marker 0100 second");
    put(LSEQ, ld(8'h25), LSEQ, ld(8'hB2), 1'b1, 1, W_IDLE, 4'b1111, "R7 truncated");
    put(LI, LI, LI, LI, 1'b1, 1, W_IDLE, 4'b1111, "R4 idle after truncated");
    put(LI, LFC, LI, LI, 1'b1, 1, W_ERR, 4'b1111, "R8 false carrier");
    put(LCE, LI, LI, LI, 1'b1, 1, W_ERR, 4'b1111, "R8 extend while idle");
    put(ld(8'h55), ld(8'h61), ld(8'h62), ld(8'h63), 1'b1, 1, 32'h6362_61FB, 4'b0001, "R1 start");
    put(ld(8'h01), LI, LCE, LI, 1'b1, 1, W_ERR, 4'b1111, "R8 extend misplaced");
    put(LI, LI, LI, LI, 1'b1, 1, 32'h0707_07FD, 4'b1111, "R8 state kept so R3 term");
    put(ld(8'h55), ld(8'h71), ld(8'h72), ld(8'h73), 1'b1, 1, 32'h7372_71FB, 4'b0001, "R1 start");
    put(ld(8'h74), ld(8'h75), ld(8'h76), ld(8'h77), 1'b0, 1, W_LF, 4'b0001, "R9 link drop");
    put(ld(8'h81), ld(8'h82), ld(8'h83), ld(8'h84), 1'b1, 1, 32'h8483_82FB, 4'b0001, "R9 state cleared");
    put(LI, LI, LI, LI, 1'b1, 1, 32'h0707_07FD, 4'b1111, "R3 term after recovery");
    repeat (4) put(LI, LI, LI, LI, 1'b1, 0, '0, '0, "");
    while (due_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule